// File: doc/BRIEF.md
# Slow-Memory Interface Configuration Register

This block is the configuration and status register of an external slow-memory port, together with the small amount of logic that its fields drive directly. Software reaches it through a strobe-based register port. A write updates four control bits in the next clock cycle. A read returns the whole 32-bit word combinationally, in the same cycle as the read strobe.

The control bits do the following:
- The write-protect bit drives the flash write-protect pin.
- The boot-swap bit selects which of two 32 MiB address windows belongs to chip select 0 and which to chip select 3. This bit is loaded from a boot pin during reset and can later be overwritten.
- The two power-down bits produce a clock-cut request and qualify the idle acknowledge.

The flash ready pin passes through a synchroniser and appears as a read-only status bit.

Top module: `mif_cfg_reg`

## Requirements
- R1: While `rst` is high at a clock edge, write-protect, unit power-down and global power-down are cleared and the boot-swap bit (bit 1) takes the value of `boot_pin_i`.
- R2: A write strobe stores `wr_data_i[3:0]` into write-protect (bit 0), boot-swap (bit 1), unit power-down (bit 2) and global power-down (bit 3), and a later read returns them at those positions.
- R3: Read data bits 31 to 5 are always 0, and values written to those bits have no effect.
- R4: Bit 4 reads the level of `flash_rdy_i` as seen after two clock edges, and writes to bit 4 have no effect.
- R5: `flash_wp_o` equals bit 0 of the register from the edge that wrote it and otherwise holds.
- R6: With boot-swap 0, `sel0_o` is high for addresses 0x0000_0000 to 0x01FF_FFFF and `sel3_o` is high for 0x0C00_0000 to 0x0DFF_FFFF.
- R7: With boot-swap 1, the two windows are exchanged.
- R8: An address outside both windows raises neither select, and the two selects are never high together.
- R9: The decode follows a boot-swap write from the cycle after the write.
- R10: `clk_cut_o` is high exactly when both power-down bits are 1.
- R11: `idle_ack_o` is high in the cycle after `idle_req_i` is high, and only if unit power-down is set. Otherwise it is low.
- R12: `rd_data_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Register read data, valid with the read strobe |
| boot_pin_i | input | 1 | Boot-mode pin, sampled while reset is high |
| flash_rdy_i | input | 1 | Asynchronous flash ready pin |
| flash_wp_o | output | 1 | Flash write-protect pin |
| addr_i | input | 32 | Access address to decode |
| sel0_o | output | 1 | Chip select 0 |
| sel3_o | output | 1 | Chip select 3 |
| idle_req_i | input | 1 | Idle request |
| idle_ack_o | output | 1 | Idle acknowledge, registered |
| clk_cut_o | output | 1 | Request to gate the unit clock |

## Verification
The bench builds the block with its defaults:
- a 32-bit address and data word,
- 32 MiB windows at bases 0x0000_0000 and 0x0C00_0000,
- a two-stage ready synchroniser.

With these values both edges of each window, and the addresses just outside them, can be driven directly. This applies under either boot-swap value. The two-stage synchroniser also lets the bench observe the exact edge at which the ready level first appears in bit 4.

// File: rtl/mif_cfg_pkg.sv
package mif_cfg_pkg;

  localparam int CTRL_W = 4;
  localparam int STAT_BIT = 4;
  localparam int USED_W = 5;

  typedef struct packed {
    logic glob_pd;
    logic unit_pd;
    logic boot_swap;
    logic wr_prot;
  } ctrl_t;

endpackage

// File: rtl/mif_sync.sv
module mif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mif_cs_decode.sv
module mif_cs_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_LOG2  = 25,
  parameter logic [31:0] LOW_BASE  = 32'h0000_0000,
  parameter logic [31:0] HIGH_BASE = 32'h0C00_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              swap_i,
  output logic              sel0_o,
  output logic              sel3_o
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] LOW_TAG  = LOW_BASE[ADDR_W-1:WIN_LOG2];
  localparam logic [TAG_W-1:0] HIGH_TAG = HIGH_BASE[ADDR_W-1:WIN_LOG2];

  logic [TAG_W-1:0] tag;
  logic             hit_low;
  logic             hit_high;
  logic             unused_offset;

  assign tag           = addr_i[ADDR_W-1:WIN_LOG2];
  assign unused_offset = ^addr_i[WIN_LOG2-1:0];
  assign hit_low       = (tag == LOW_TAG);
  assign hit_high      = (tag == HIGH_TAG);

  always_comb begin
    if (swap_i) begin
      sel0_o = hit_high;
      sel3_o = hit_low;
    end else begin
      sel0_o = hit_low;
      sel3_o = hit_high;
    end
  end

endmodule

// File: rtl/mif_pwr_gate.sv
module mif_pwr_gate (
  input  logic clk,
  input  logic rst,
  input  logic glob_pd_i,
  input  logic unit_pd_i,
  input  logic idle_req_i,
  output logic clk_cut_o,
  output logic idle_ack_o
);

  assign clk_cut_o = glob_pd_i & unit_pd_i;

  always_ff @(posedge clk) begin
    if (rst) idle_ack_o <= 1'b0;
    else     idle_ack_o <= idle_req_i & unit_pd_i;
  end

endmodule

// File: rtl/mif_cfg_reg.sv
module mif_cfg_reg
  import mif_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          WIN_LOG2    = 25,
  parameter logic [31:0] LOW_BASE    = 32'h0000_0000,
  parameter logic [31:0] HIGH_BASE   = 32'h0C00_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              boot_pin_i,
  input  logic              flash_rdy_i,
  output logic              flash_wp_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel0_o,
  output logic              sel3_o,
  input  logic              idle_req_i,
  output logic              idle_ack_o,
  output logic              clk_cut_o
);

  ctrl_t ctrl_q;
  logic  rdy_sync;
  logic  unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q           <= '0;
      ctrl_q.boot_swap <= boot_pin_i;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  mif_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk (clk),
    .rst (rst),
    .d_i (flash_rdy_i),
    .q_o (rdy_sync)
  );

  mif_cs_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE)
  ) u_decode (
    .addr_i (addr_i),
    .swap_i (ctrl_q.boot_swap),
    .sel0_o (sel0_o),
    .sel3_o (sel3_o)
  );

  mif_pwr_gate u_pwr (
    .clk        (clk),
    .rst        (rst),
    .glob_pd_i  (ctrl_q.glob_pd),
    .unit_pd_i  (ctrl_q.unit_pd),
    .idle_req_i (idle_req_i),
    .clk_cut_o  (clk_cut_o),
    .idle_ack_o (idle_ack_o)
  );

  assign flash_wp_o = ctrl_q.wr_prot;
  assign rd_data_o  = rd_en_i ? DATA_W'({rdy_sync, ctrl_q}) : '0;

endmodule

// File: rtl/mif_cfg_reg_chk.sv
module mif_cfg_reg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              flash_wp_o,
  input logic              sel0_o,
  input logic              sel3_o,
  input logic              idle_req_i,
  input logic              idle_ack_o,
  input logic              clk_cut_o
);

  p_wp_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> flash_wp_o == $past(wr_data_i[0]));

  p_wp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(flash_wp_o));

  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DATA_W-1:5] == '0);

  p_sel_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(sel0_o && sel3_o));

  p_cut_both_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && clk_cut_o) |-> (rd_data_o[3] && rd_data_o[2]));

  p_idle_noreq_r11: assert property (@(posedge clk) disable iff (rst)
    !idle_req_i |=> !idle_ack_o);

  p_rd_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |-> rd_data_o == '0);

endmodule

bind mif_cfg_reg mif_cfg_reg_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_mif_cfg_reg.sv
module test_mif_cfg_reg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        boot_pin = 1'b0;
  logic        flash_rdy = 1'b0;
  logic        flash_wp;
  logic [31:0] addr = '0;
  logic        sel0, sel3;
  logic        idle_req = 1'b0;
  logic        idle_ack;
  logic        clk_cut;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;
  logic [31:0] rv;

  // entry: {boot_swap, address, expected sel0, expected sel3}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 1'b1, 1'b0},
    {1'b0, 32'h01FF_FFFF, 1'b1, 1'b0},
    {1'b0, 32'h0200_0000, 1'b0, 1'b0},
    {1'b0, 32'h0C00_0000, 1'b0, 1'b1},
    {1'b0, 32'h0DFF_FFFF, 1'b0, 1'b1},
    {1'b0, 32'h0E00_0000, 1'b0, 1'b0},
    {1'b1, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 32'h01FF_FFFF, 1'b0, 1'b1},
    {1'b1, 32'h0C00_0000, 1'b1, 1'b0},
    {1'b1, 32'h0DFF_FFFF, 1'b1, 1'b0},
    {1'b1, 32'h0BFF_FFFF, 1'b0, 1'b0},
    {1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0}
  };

  mif_cfg_reg i_mif_cfg_reg (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .boot_pin_i(boot_pin),
    .flash_rdy_i(flash_rdy), .flash_wp_o(flash_wp), .addr_i(addr),
    .sel0_o(sel0), .sel3_o(sel3), .idle_req_i(idle_req),
    .idle_ack_o(idle_ack), .clk_cut_o(clk_cut)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    rd_en = 1'b1;
    #1;
    v = rd_data;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst = 1'b1;
    boot_pin = pin;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    boot_pin = ~pin;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with boot pin high, then low
    do_reset(1'b1);
    rd(rv);
    chk("R1 boot pin 1", rv, 32'h2);
    chk("R1 wp reset", {31'b0, flash_wp}, 32'h0);
    do_reset(1'b0);
    rd(rv);
    chk("R1 boot pin 0", rv, 32'h0);

    // R12: no read strobe gives zero
    wr(32'h0000_0009);
    #1;
    chk("R12 idle read bus", rd_data, 32'h0);

    // R2 R3 R4 R5 R10: write all ones
    wr(32'hFFFF_FFFF);
    rd(rv);
    chk("R2 R3 R4 all ones", rv, 32'h0000_000F);
    chk("R5 wp high", {31'b0, flash_wp}, 32'h1);
    chk("R10 both set", {31'b0, clk_cut}, 32'h1);
    wr(32'hFFFF_FFF0);
    rd(rv);
    chk("R3 reserved ignored", rv, 32'h0);
    chk("R5 wp low", {31'b0, flash_wp}, 32'h0);
    wr(32'h0000_0005);
    rd(rv);
    chk("R2 pattern 5", rv, 32'h5);

    // R10: single enables do not cut
    wr(32'h0000_0004);
    chk("R10 unit only", {31'b0, clk_cut}, 32'h0);
    wr(32'h0000_0008);
    chk("R10 global only", {31'b0, clk_cut}, 32'h0);

    // R11: idle ack with global only -> low
    idle_req = 1'b1;
    @(negedge clk);
    chk("R11 no unit pd", {31'b0, idle_ack}, 32'h0);
    idle_req = 1'b0;
    wr(32'h0000_0004);
    idle_req = 1'b1;
    @(negedge clk);
    chk("R11 unit pd set", {31'b0, idle_ack}, 32'h1);
    idle_req = 1'b0;
    @(negedge clk);
    chk("R11 request dropped", {31'b0, idle_ack}, 32'h0);

    // R4: ready synchroniser latency
    flash_rdy = 1'b1;
    @(negedge clk);
    rd(rv);
    chk("R4 one edge", rv, 32'h4);
    @(negedge clk);
    rd(rv);
    chk("R4 two edges", rv, 32'h14);
    wr(32'h0000_0000);
    flash_rdy = 1'b0;
    rd(rv);
    chk("R4 write does not clear", rv, 32'h10);
    repeat (2) @(negedge clk);
    rd(rv);
    chk("R4 low level", rv, 32'h0);

    // R9: decode follows the boot-swap write next cycle
    addr = 32'h0000_0000;
    #1;
    chk("R9 before write", {30'b0, sel0, sel3}, 32'h2);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h2;
    #1;
    chk("R9 write cycle", {30'b0, sel0, sel3}, 32'h2);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R9 after write", {30'b0, sel0, sel3}, 32'h1);

    // R6 R7 R8: decode table
    for (int i = 0; i < NV; i++) begin
      wr({30'b0, VEC[i][34], 1'b0});
      addr = VEC[i][33:2];
      #1;
      chk(VEC[i][34] ? "R7 R8 swapped decode" : "R6 R8 plain decode",
          {30'b0, sel0, sel3}, {30'b0, VEC[i][1:0]});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule